// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is the write side of a byte-wide nonvolatile memory that holds a page register in front of its storage array. A host issues write strobes, each carrying an address and a data byte. The first accepted strobe opens a load window and fixes the page. Later strobes to the same page fill a byte buffer and set one bit each in a valid mask. When no byte arrives for a set number of cycles, the window closes. The block then runs an internal programming period of fixed length. During that period it copies only the marked bytes into the array and reports busy.

The array is a plain synchronous memory with a registered read port, so the host can read back what was programmed. The address width is a parameter. The full-size part uses 13 bits; the default here is 11, which keeps the elaborated array small. The low six address bits pick the byte inside a page and the remaining upper bits pick the page. The load timeout and the programming time are counted in clock cycles. A 125 MHz clock gives 18 750 cycles for the byte-load limit and 1 250 000 cycles for the programming period.

Top module: `page_write_ctrl`

## Requirements
- R1: A byte is accepted only on a clock where `we` is high and was low on the previous clock, while `ce` is high and `oe` is low. A strobe taken with `oe` high, with `ce` low, or with `we` held steady high changes neither the array nor the `last_addr`/`last_data` outputs and starts no programming.
- R2: Address bits [5:0] select the byte within a page and bits [ADDR_W-1:6] select the page. A single byte written to page p, offset o ends up at array location p*64+o.
- R3: The first accepted byte fixes the page for the window. A later strobe in the same window whose page bits differ is dropped and sets `page_err`. `page_err` stays high until the block returns to idle after programming.
- R4: Bytes may arrive in any offset order. A byte written again to the same offset within one window replaces the earlier value.
- R5: The load window closes when LOAD_CYC clocks pass after the last accepted byte with no new accepted byte. `busy` is first seen high LOAD_CYC clocks after the clock that accepted that byte.
- R6: `busy` stays high for exactly PROG_CYC clocks. Write strobes during that time are ignored.
- R7: Programming writes only the offsets marked in the window. Every other byte of the page and of the array keeps its old value.
- R8: `last_addr` and `last_data` hold the address and data of the most recently accepted byte. A dropped strobe does not change them.
- R9: A synchronous active-high reset clears `busy`, `page_err`, the byte mask, `last_addr`, `last_data` and `rdata`.
- R10: When `ce` and `oe` are both high at a clock, `rdata` shows the array byte at `addr` after that clock and holds it until the next such read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Chip enable, active high |
| oe | input | 1 | Output enable, active high; inhibits writes |
| we | input | 1 | Write enable; a rising level starts a byte write |
| addr | input | ADDR_W | Byte address (page in the upper bits, offset in the low 6) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered array read data |
| busy | output | 1 | High during the programming period |
| page_err | output | 1 | Sticky flag for a strobe to a foreign page |
| last_addr | output | ADDR_W | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |

## Verification
Every output is registered, so each result is due one clock after the edge that samples its cause. The exceptions are `busy`, which rises LOAD_CYC clocks after the last accepted byte and falls PROG_CYC clocks later. The bench drives inputs and samples outputs on the falling edge. A behavioural reference model advances on the rising edge, and the bench compares all outputs against it on every falling edge. Directed checks count the clocks from the accepting edge to `busy` and the number of falling edges with `busy` high, and compare those counts with the two parameters.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_LOAD = 2'd1,
    PW_PROG = 2'd2
  } pw_state_t;
endpackage

// File: rtl/pwc_strobe_qual.sv
// Qualifies a write: rising write enable with chip enabled and output disabled.
module pwc_strobe_qual (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic oe,
  input  logic we,
  output logic accept
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we;
  end

  assign accept = we & ~we_q & ce & ~oe;
endmodule

// File: rtl/pwc_page_latch.sv
// Page register: one byte slot and one valid bit per offset.
module pwc_page_latch #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int OFFS_W    = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  ld,
  input  logic                  first,
  input  logic [OFFS_W-1:0]     offs,
  input  logic [DATA_W-1:0]     din,
  input  logic [OFFS_W-1:0]     sel_idx,
  output logic [PAGE_BYTES-1:0] mask,
  output logic [DATA_W-1:0]     sel_byte
);
  logic [DATA_W-1:0] slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < PAGE_BYTES; g++) begin : g_hit
      assign hit[g] = ld && (offs == OFFS_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask <= '0;
    end else if (ld) begin
      // A new window starts with only the current byte marked.
      mask <= first ? hit : (mask | hit);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (hit[i]) slot_q[i] <= din;
    end
  end

  assign sel_byte = slot_q[sel_idx];
endmodule

// File: rtl/pwc_store.sv
// Storage array: one write port, one registered read port.
module pwc_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int LOAD_CYC   = 18750,
  parameter int PROG_CYC   = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              oe,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              page_err,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data
);
  import pwc_pkg::*;

  localparam int OFFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W  = ADDR_W - OFFS_W;
  localparam int CNT_MAX = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
  localparam logic [CNT_W-1:0] LOAD_END = CNT_W'(LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_END = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SWEEP_N  = CNT_W'(PAGE_BYTES);

  pw_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;

  logic                  accept, page_hit, ld, first, clr;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     sweep_byte;
  logic [OFFS_W-1:0]     sweep_idx;
  logic                  arr_we;

  pwc_strobe_qual u_qual (
    .clk(clk), .rst(rst), .ce(ce), .oe(oe), .we(we), .accept(accept)
  );

  assign page_hit = (addr[ADDR_W-1:OFFS_W] == page_q);
  assign first    = (state_q == PW_IDLE);
  assign ld       = accept && ((state_q == PW_IDLE) || ((state_q == PW_LOAD) && page_hit));
  assign clr      = (state_q == PW_PROG) && (cnt_q == PROG_END);

  // The sweep over the page uses the first PAGE_BYTES clocks of programming
  // (PROG_CYC must be at least PAGE_BYTES).
  assign sweep_idx = cnt_q[OFFS_W-1:0];
  assign arr_we    = (state_q == PW_PROG) && (cnt_q < SWEEP_N) && mask[sweep_idx];

  pwc_page_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld), .first(first),
    .offs(addr[OFFS_W-1:0]), .din(wdata), .sel_idx(sweep_idx),
    .mask(mask), .sel_byte(sweep_byte)
  );

  pwc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr(arr_we), .waddr({page_q, sweep_idx}),
    .wdata(sweep_byte), .re(ce & oe), .raddr(addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PW_IDLE;
      cnt_q     <= '0;
      page_q    <= '0;
      busy      <= 1'b0;
      page_err  <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      if (ld) begin
        last_addr <= addr;
        last_data <= wdata;
      end
      unique case (state_q)
        PW_IDLE: begin
          if (ld) begin
            page_q  <= addr[ADDR_W-1:OFFS_W];
            cnt_q   <= '0;
            state_q <= PW_LOAD;
          end
        end
        PW_LOAD: begin
          if (ld) begin
            cnt_q <= '0;
          end else begin
            if (accept) page_err <= 1'b1;
            if (cnt_q == LOAD_END) begin
              cnt_q   <= '0;
              busy    <= 1'b1;
              state_q <= PW_PROG;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PW_PROG: begin
          if (clr) begin
            cnt_q    <= '0;
            busy     <= 1'b0;
            page_err <= 1'b0;
            state_q  <= PW_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwc_checks.sv
module pwc_checks #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  page_err,
  input logic [ADDR_W-1:0]     last_addr,
  input logic [DATA_W-1:0]     last_data,
  input logic [PAGE_BYTES-1:0] mask,
  input logic                  arr_we,
  input logic                  ld
);
  p_store_in_prog_r7: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  p_busy_ignores_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(last_addr) && $stable(last_data)));

  p_no_load_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ld);

  p_mask_empty_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (mask == '0));

  p_err_clears_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(page_err) |-> $fell(busy));

  p_err_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    page_err |-> (busy || (mask != '0)));
endmodule

bind page_write_ctrl pwc_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
) u_checks (
  .clk(clk), .rst(rst), .busy(busy), .page_err(page_err),
  .last_addr(last_addr), .last_data(last_data), .mask(mask),
  .arr_we(arr_we), .ld(ld)
);

// File: tb/page_write_ctrl_bench.sv
`timescale 1ns/1ps
module page_write_ctrl_bench;
  localparam int AW   = 11;
  localparam int LOAD = 8;
  localparam int PROG = 80;

  logic clk = 1'b0;
  logic rst, ce, oe, we;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata, last_data;
  logic busy, page_err;
  logic [AW-1:0] last_addr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  page_write_ctrl #(.ADDR_W(AW), .LOAD_CYC(LOAD), .PROG_CYC(PROG)) u_page_write_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .oe(oe), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .page_err(page_err),
    .last_addr(last_addr), .last_data(last_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int  m_state = 0, m_cnt = 0, m_page = 0;
  bit  m_weq = 1, m_err = 0;
  int  m_last_a = 0, m_last_d = 0, m_rd = 0;
  bit  m_mask [64];
  int  m_buf  [64];
  int  m_mem  [2048];

  initial foreach (m_mem[i]) m_mem[i] = 0;

  always @(posedge clk) begin
    bit acc;
    acc = we && !m_weq && ce && !oe;
    m_weq = we;
    if (rst) begin
      m_weq = 1; m_state = 0; m_cnt = 0; m_err = 0;
      m_last_a = 0; m_last_d = 0; m_rd = 0;
      foreach (m_mask[i]) m_mask[i] = 0;
    end else begin
      if (ce && oe) m_rd = m_mem[addr];
      if (m_state == 0) begin
        if (acc) begin
          foreach (m_mask[i]) m_mask[i] = 0;
          m_page = addr / 64;
          m_buf[addr % 64] = wdata; m_mask[addr % 64] = 1;
          m_last_a = addr; m_last_d = wdata; m_cnt = 0; m_state = 1;
        end
      end else if (m_state == 1) begin
        if (acc && (addr / 64 == m_page)) begin
          m_buf[addr % 64] = wdata; m_mask[addr % 64] = 1;
          m_last_a = addr; m_last_d = wdata; m_cnt = 0;
        end else begin
          if (acc) m_err = 1;
          if (m_cnt == LOAD - 1) begin m_cnt = 0; m_state = 2; end
          else m_cnt++;
        end
      end else begin
        if (m_cnt == PROG - 1) begin
          foreach (m_mask[i]) if (m_mask[i]) m_mem[m_page * 64 + i] = m_buf[i];
          foreach (m_mask[i]) m_mask[i] = 0;
          m_err = 0; m_cnt = 0; m_state = 0;
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 busy", busy, m_state == 2);
      chk("R3 page_err", page_err, m_err);
      chk("R8 last_addr", last_addr, m_last_a);
      chk("R8 last_data", last_data, m_last_d);
      chk("R10 rdata", rdata, m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); ce = 1; oe = 0; we = 0; addr = AW'(a); wdata = 8'(d);
    @(negedge clk); we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); ce = 1; oe = 1; we = 0; addr = AW'(a);
    @(negedge clk); v = rdata; oe = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, k, n;
    rst = 1; ce = 0; oe = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 page_err", page_err, 0);
    chk("R9 last_addr", last_addr, 0);
    chk("R9 rdata", rdata, 0);
    rst = 0;

    // R2: single byte, page 3 offset 5
    wr(3 * 64 + 5, 'hA5);
    wait_idle();
    rd(197, v); chk("R2 byte location", v, 'hA5);
    rd(196, v); chk("R7 neighbour untouched", v, 0);

    // R4: out of order, rewrite wins
    wr(5 * 64 + 10, 'h11);
    wr(5 * 64 + 2,  'h22);
    wr(5 * 64 + 10, 'h33);
    wait_idle();
    rd(5 * 64 + 10, v); chk("R4 last write wins", v, 'h33);
    rd(5 * 64 + 2,  v); chk("R4 any order", v, 'h22);
    rd(5 * 64 + 3,  v); chk("R7 unmarked byte", v, 0);

    // R3: foreign page strobe dropped
    wr(7 * 64, 'h44);
    wr(8 * 64 + 1, 'h55);
    @(negedge clk);
    chk("R3 error raised", page_err, 1);
    chk("R8 dropped keeps last", last_addr, 7 * 64);
    wait_idle();
    chk("R3 error cleared", page_err, 0);
    rd(8 * 64 + 1, v); chk("R3 foreign byte not stored", v, 0);
    rd(7 * 64, v); chk("R7 window byte stored", v, 'h44);

    // R1: inhibited strobes
    @(negedge clk); ce = 1; oe = 1; addr = AW'(100); wdata = 8'h66; we = 0;
    @(negedge clk); we = 1;
    @(negedge clk); we = 0; ce = 0; oe = 0;
    @(negedge clk); we = 1;
    @(negedge clk); we = 0;
    repeat (LOAD + 4) @(negedge clk);
    chk("R1 no programming", busy, 0);
    chk("R1 last unchanged", last_addr, 7 * 64);
    rd(100, v); chk("R1 array unchanged", v, 0);

    // R5 / R6: timing, and strobes during busy ignored
    @(negedge clk); ce = 1; oe = 0; we = 0; addr = AW'(9 * 64 + 4); wdata = 8'h77;
    @(negedge clk); we = 1;
    k = 0;
    forever begin
      @(posedge clk); k++;
      @(negedge clk); we = 0;
      if (busy) break;
    end
    chk("R5 window closes", k, LOAD + 1);
    addr = AW'(9 * 64 + 6); wdata = 8'h88;
    n = 1;
    for (int i = 1; i < 4 * PROG; i++) begin
      @(negedge clk);
      we = (i == 1);
      if (!busy) break;
      n++;
    end
    chk("R6 busy length", n, PROG);
    chk("R6 strobe ignored", last_addr, 9 * 64 + 4);
    rd(9 * 64 + 6, v); chk("R6 busy write dropped", v, 0);
    rd(9 * 64 + 4, v); chk("R7 programmed byte", v, 'h77);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule